// File: doc/BRIEF.md
# Programmable PWM Channel Generator

This block produces one pulse-width-modulated output from a system clock. A two-stage prescaler cuts the clock into quanta: an 8-bit linear count sets a base length and a 4-bit shift scales it by a power of two. An 8-bit period counter then steps once per quantum and wraps after a programmable number of quanta. The output is active over a window inside each period that a rising point and a falling point set. A falling point below the rising point makes the window wrap across the period boundary. Equal points keep the output active for the whole period.

Software drives the block through two 32-bit words: a control word and a timing word. Each is written with a one-cycle write strobe. The control word holds the divider fields, a counter-run enable, an output-pin enable, a polarity inversion bit and a bit that turns off synchronised updates. With synchronised updates on, new period, point and divider values wait in shadow storage and take effect at the next period start, so a running waveform never shows a period with mixed settings. Enables and inversion always act at once.

Top module: `pwm_chan_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `pwm_out` is 0 and every stored field is zero.
- R2: One quantum lasts (LIN + 1) << SHF clock cycles and one period lasts (PER + 1) quanta. LIN is control bits [7:0], SHF is control bits [11:8] and PER is timing bits [31:24].
- R3: With rising point RP (timing bits [7:0]) below falling point FP (timing bits [15:8]), the output is active for quanta RP to FP-1 of each period. With RP = 0 it goes active at the period start and stays active for FP quanta.
- R4: When RP equals FP, the output is active for the whole period.
- R5: When RP is above FP, the output is active for quanta RP to PER and for quanta 0 to FP-1.
- R6: While the run bit (control bit 16) is 0, both counters are held at zero and the waveform is inactive. This takes effect in the cycle after the control write, even in mid-period. Timing values written during this time are used from quantum 0 once the run bit is set again.
- R7: While the pin-enable bit (control bit 12) is 0, the output shows the inactive level whatever the counters hold.
- R8: `pwm_out` equals the inversion bit (control bit 14) XOR (pin enable AND run AND waveform-active). A change of the inversion bit shows in the cycle after its write, without waiting for a period boundary.
- R9: With the sync-off bit (control bit 17) at 0 and the run bit at 1, a new period, point or divider value written during a period is not used until the next period begins.
- R10: With the sync-off bit at 1, a written timing or divider value is in use two cycles after its write strobe, and the current period is reshaped by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control word: sync-off, run, invert, pin enable, shift, linear count |
| duty_we | input | 1 | Write strobe for the timing word |
| duty_wdata | input | 32 | Timing word: period, falling point, rising point |
| pwm_out | output | 1 | Gated and polarity-corrected waveform |

## Verification
A wrong quantum or period counter shows at the port as a wrong spacing between rising edges or a wrong high time, so the bench measures both over whole periods for linear-only, shifted, wrapped and full-window settings. A shadow-to-active transfer that comes too early or too late only shows in the single period in which a write lands. The bench therefore writes a new falling point one quantum into a pulse and checks the length of that pulse and of the next one, with synchronised updates on and off. Gating and inversion faults are checked in the cycle right after the control write, because the block promises an effect there.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    // Field widths of the programming words
    localparam int LIN_W = 8;   // linear prescaler count
    localparam int SHF_W = 4;   // prescaler shift
    localparam int CNT_W = 8;   // period counter and points
    localparam int WORD_W = 32;
    // Quantum counter width: (2^LIN_W) << (2^SHF_W - 1) needs this many bits
    localparam int QNT_W = LIN_W + (1 << SHF_W);

    // Control word bit positions
    localparam int CB_SYNC_OFF = 17;
    localparam int CB_RUN      = 16;
    localparam int CB_INV      = 14;
    localparam int CB_PIN      = 12;
    localparam int CB_SHF_LO   = 8;
    localparam int CB_LIN_LO   = 0;

    // Timing word bit positions
    localparam int TB_PER_LO  = 24;
    localparam int TB_FALL_LO = 8;
    localparam int TB_RISE_LO = 0;

    typedef struct packed {
        logic             sync_off;
        logic             run;
        logic             inv;
        logic             pin_en;
    } gate_t;

    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] fall;
        logic [CNT_W-1:0] rise;
        logic [SHF_W-1:0] shf;
        logic [LIN_W-1:0] lin;
    } shape_t;

    function automatic gate_t get_gate(input logic [WORD_W-1:0] w);
        gate_t g;
        g.sync_off = w[CB_SYNC_OFF];
        g.run      = w[CB_RUN];
        g.inv      = w[CB_INV];
        g.pin_en   = w[CB_PIN];
        return g;
    endfunction

    // Last count value of one quantum: ((lin+1) << shf) - 1
    function automatic logic [QNT_W-1:0] quantum_last(input logic [LIN_W-1:0] lin,
                                                      input logic [SHF_W-1:0] shf);
        logic [QNT_W-1:0] base;
        base = {{(QNT_W-LIN_W){1'b0}}, lin} + {{(QNT_W-1){1'b0}}, 1'b1};
        return (base << shf) - {{(QNT_W-1){1'b0}}, 1'b1};
    endfunction

    // Whether quantum p lies inside the active window
    function automatic logic window_on(input logic [CNT_W-1:0] p,
                                       input logic [CNT_W-1:0] rise,
                                       input logic [CNT_W-1:0] fall);
        if (rise == fall)
            return 1'b1;
        else if (rise < fall)
            return (p >= rise) && (p < fall);
        else
            return (p >= rise) || (p < fall);
    endfunction

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
    import pwm_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [WORD_W-1:0] ctrl_wdata,
    input  logic              duty_we,
    input  logic [WORD_W-1:0] duty_wdata,
    input  logic              boundary,
    output gate_t             gate,
    output shape_t            act
);

    shape_t shd;
    logic   apply_now;
    logic   ctrl_unused;
    logic   duty_unused;

    assign ctrl_unused = ^{ctrl_wdata[WORD_W-1:CB_SYNC_OFF+1], ctrl_wdata[15], ctrl_wdata[13]};
    assign duty_unused = ^duty_wdata[TB_PER_LO-1:TB_FALL_LO+CNT_W];

    // Shadow copies pass to the active set when no period is running,
    // when sync is off, or on the last cycle of a period.
    assign apply_now = !gate.run || gate.sync_off || boundary;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate <= '0;
            shd  <= '0;
            act  <= '0;
        end else begin
            if (ctrl_we) begin
                gate    <= get_gate(ctrl_wdata);
                shd.shf <= ctrl_wdata[CB_SHF_LO +: SHF_W];
                shd.lin <= ctrl_wdata[CB_LIN_LO +: LIN_W];
            end
            if (duty_we) begin
                shd.per  <= duty_wdata[TB_PER_LO +: CNT_W];
                shd.fall <= duty_wdata[TB_FALL_LO +: CNT_W];
                shd.rise <= duty_wdata[TB_RISE_LO +: CNT_W];
            end
            if (apply_now)
                act <= shd;
        end
    end

    // R9
    held_in_period_chk: assert property (@(posedge clk) disable iff (rst)
        (gate.run && !gate.sync_off && !boundary) |=> $stable(act));

endmodule

// File: rtl/pwm_chan_prescaler.sv
module pwm_chan_prescaler
    import pwm_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [LIN_W-1:0] lin,
    input  logic [SHF_W-1:0] shf,
    output logic             tick
);

    logic [QNT_W-1:0] q_cnt;
    logic [QNT_W-1:0] q_last;

    assign q_last = quantum_last(lin, shf);
    // >= so that a shortened quantum under unsynchronised writes still ends
    assign tick   = run && (q_cnt >= q_last);

    always_ff @(posedge clk) begin
        if (rst || !run)
            q_cnt <= '0;
        else if (tick)
            q_cnt <= '0;
        else
            q_cnt <= q_cnt + {{(QNT_W-1){1'b0}}, 1'b1};
    end

    // R6
    stopped_quantum_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run)) |-> (q_cnt == '0));

endmodule

// File: rtl/pwm_chan_period.sv
module pwm_chan_period
    import pwm_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] per,
    output logic [CNT_W-1:0] p_cnt,
    output logic             boundary
);

    logic at_end;

    assign at_end   = p_cnt >= per;
    assign boundary = tick && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run)
            p_cnt <= '0;
        else if (tick)
            p_cnt <= at_end ? '0 : p_cnt + {{(CNT_W-1){1'b0}}, 1'b1};
    end

    // R2
    step_on_tick_only_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> (!run || $stable(p_cnt)));

endmodule

// File: rtl/pwm_chan_gen.sv
module pwm_chan_gen
    import pwm_chan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_we,
    input  logic [31:0] ctrl_wdata,
    input  logic        duty_we,
    input  logic [31:0] duty_wdata,
    output logic        pwm_out
);

    gate_t            gate;
    shape_t           act;
    logic             tick;
    logic             boundary;
    logic [CNT_W-1:0] p_cnt;
    logic             wave;
    logic             drive;

    pwm_chan_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .duty_we    (duty_we),
        .duty_wdata (duty_wdata),
        .boundary   (boundary),
        .gate       (gate),
        .act        (act)
    );

    pwm_chan_prescaler u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (gate.run),
        .lin  (act.lin),
        .shf  (act.shf),
        .tick (tick)
    );

    pwm_chan_period u_period (
        .clk      (clk),
        .rst      (rst),
        .run      (gate.run),
        .tick     (tick),
        .per      (act.per),
        .p_cnt    (p_cnt),
        .boundary (boundary)
    );

    assign wave    = window_on(p_cnt, act.rise, act.fall);
    assign drive   = gate.pin_en && gate.run && wave;
    assign pwm_out = gate.inv ^ drive;

    // R2
    wrap_to_start_chk: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (p_cnt == '0));

    // R4
    full_window_chk: assert property (@(posedge clk) disable iff (rst)
        (gate.run && gate.pin_en && act.rise == act.fall) |-> (pwm_out == !gate.inv));

    // R7
    pin_off_chk: assert property (@(posedge clk) disable iff (rst)
        !gate.pin_en |-> (pwm_out == gate.inv));

    // R6
    stop_inactive_chk: assert property (@(posedge clk) disable iff (rst)
        !gate.run |-> (pwm_out == gate.inv));

endmodule

// File: tb/pwm_chan_gen_test.sv
module pwm_chan_gen_test;

    localparam logic [31:0] W_SYNC_OFF = 32'h1 << 17;
    localparam logic [31:0] W_RUN      = 32'h1 << 16;
    localparam logic [31:0] W_INV      = 32'h1 << 14;
    localparam logic [31:0] W_PIN      = 32'h1 << 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        duty_we = 1'b0;
    logic [31:0] duty_wdata = '0;
    logic        pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pwm_chan_gen uut (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .duty_we    (duty_we),
        .duty_wdata (duty_wdata),
        .pwm_out    (pwm_out)
    );

    function automatic logic [31:0] tword(input int per, input int fall, input int rise);
        return {per[7:0], 8'h00, fall[7:0], rise[7:0]};
    endfunction

    function automatic logic [31:0] divw(input int lin, input int shf);
        return {20'h0, shf[3:0], lin[7:0]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [31:0] w);
        ctrl_wdata = w;
        ctrl_we    = 1'b1;
        @(negedge clk);
        ctrl_we    = 1'b0;
    endtask

    task automatic wr_duty(input logic [31:0] w);
        duty_wdata = w;
        duty_we    = 1'b1;
        @(negedge clk);
        duty_we    = 1'b0;
    endtask

    // stop, load timing while stopped, then start with the full control word
    task automatic setup(input logic [31:0] c, input logic [31:0] t);
        wr_ctrl(c & ~W_RUN);
        wr_duty(t);
        wr_ctrl(c);
    endtask

    task automatic wait_rise();
        logic prev;
        int   g;
        prev = pwm_out;
        g = 0;
        @(negedge clk);
        while (!(!prev && pwm_out) && g < 5000) begin
            prev = pwm_out;
            @(negedge clk);
            g++;
        end
    endtask

    // high time and rise-to-rise spacing of one period, in clock cycles
    task automatic measure(output int hi, output int per);
        logic prev;
        wait_rise();
        hi = 0;
        per = 0;
        do begin
            if (pwm_out) hi++;
            per++;
            prev = pwm_out;
            @(negedge clk);
        end while (!(!prev && pwm_out) && per < 5000);
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) hi++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1 out during reset", int'(pwm_out), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out after reset", int'(pwm_out), 0);
    endtask

    task automatic t_basic();
        int hi, per;
        setup(W_RUN | W_PIN | divw(0, 0), tword(9, 3, 0));
        measure(hi, per);
        check("R3 high time", hi, 3);
        check("R2 period linear", per, 10);
    endtask

    task automatic t_prescale();
        int hi, per;
        setup(W_RUN | W_PIN | divw(2, 1), tword(4, 2, 0));
        measure(hi, per);
        check("R2 period scaled", per, 30);
        check("R3 high time scaled", hi, 12);
    endtask

    task automatic t_full_and_inv();
        int hi;
        setup(W_RUN | W_PIN | divw(0, 0), tword(9, 5, 5));
        count_high(40, hi);
        check("R4 equal points always on", hi, 40);
        wr_ctrl(W_RUN | W_PIN | W_INV | divw(0, 0));
        check("R8 inversion next cycle", int'(pwm_out), 0);
    endtask

    task automatic t_wrap();
        int hi, per;
        setup(W_RUN | W_PIN | divw(0, 0), tword(9, 2, 7));
        measure(hi, per);
        check("R5 wrapped high time", hi, 5);
        check("R5 wrapped period", per, 10);
    endtask

    task automatic t_inverted();
        int hi, per;
        setup(W_RUN | W_PIN | W_INV | divw(0, 0), tword(9, 3, 0));
        measure(hi, per);
        check("R8 inverted high time", hi, 7);
        check("R8 inverted period", per, 10);
    endtask

    task automatic t_pin_off();
        int hi;
        setup(W_RUN | divw(0, 0), tword(9, 3, 0));
        count_high(40, hi);
        check("R7 pin off normal level", hi, 0);
        wr_ctrl(W_RUN | W_INV | divw(0, 0));
        count_high(40, hi);
        check("R7 pin off inverted level", hi, 40);
    endtask

    task automatic t_stop_restart();
        int hi;
        setup(W_RUN | W_PIN | divw(0, 0), tword(9, 6, 0));
        wait_rise();
        wr_ctrl(W_PIN | divw(0, 0));
        check("R6 stop mid pulse", int'(pwm_out), 0);
        wr_duty(tword(9, 4, 0));
        count_high(20, hi);
        check("R6 stays inactive", hi, 0);
        wr_ctrl(W_RUN | W_PIN | divw(0, 0));
        check("R6 restart at quantum 0", int'(pwm_out), 1);
        count_high(10, hi);
        check("R6 value written while stopped", hi, 4);
    endtask

    task automatic t_update(input logic sync_off, input int exp_now);
        int hi, per;
        logic [31:0] c;
        c = W_RUN | W_PIN | divw(0, 0) | (sync_off ? W_SYNC_OFF : 32'h0);
        setup(c, tword(9, 3, 0));
        wait_rise();
        hi = 1;
        wr_duty(tword(9, 6, 0));
        while (pwm_out && hi < 500) begin
            hi++;
            @(negedge clk);
        end
        measure(hi, per);
        if (sync_off) begin
            check("R10 next pulse", hi, 6);
        end else begin
            check("R9 next pulse", hi, 6);
        end
        hi = exp_now;
    endtask

    task automatic t_sync_pair();
        int hi, per;
        // synchronised: pulse in flight keeps its old falling point
        setup(W_RUN | W_PIN | divw(0, 0), tword(9, 3, 0));
        wait_rise();
        hi = 1;
        wr_duty(tword(9, 6, 0));
        while (pwm_out && hi < 500) begin hi++; @(negedge clk); end
        check("R9 pulse in flight", hi, 3);
        measure(hi, per);
        check("R9 following pulse", hi, 6);
        // unsynchronised: pulse in flight is stretched
        setup(W_SYNC_OFF | W_RUN | W_PIN | divw(0, 0), tword(9, 3, 0));
        wait_rise();
        hi = 1;
        wr_duty(tword(9, 6, 0));
        while (pwm_out && hi < 500) begin hi++; @(negedge clk); end
        check("R10 pulse in flight", hi, 6);
        measure(hi, per);
        check("R10 following period", per, 10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_prescale();
        t_full_and_inv();
        t_wrap();
        t_inverted();
        t_pin_off();
        t_stop_restart();
        t_sync_pair();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule